// File: doc/BRIEF.md
# Prescaled Independent Watchdog Timer

This block is a watchdog that runs on its own slow clock, nominally 40 kHz, separate from the main system clock. Once software starts it, a down-counter steps down once every prescaled period, starting from a reload value of up to 12 bits. Software must write a refresh key before the count runs out. If it does not, the block raises a reset request for a single clock and then starts the same countdown again. After counting has begun, nothing but the block's own reset can halt it.

Software drives the block through a 16-bit key port and a configuration port. The configuration port carries a 3-bit division code and the reload value. Configuration writes take effect only while the configuration is unlocked. Writing the unlock key opens it, and any other key closes it again. The reload width and the key values are parameters. The default reload width is 12 bits, so the longest timeout is 256 × 4096 slow-clock periods, about 26.2 s at 40 kHz.

Top module: `wdt_top`

## Requirements
- R1: After reset the block is idle and `wdt_rst_o` stays low until a start key arrives. The reset configuration is division code 0 and a reload of all ones. Started with no configuration written, the first expiry therefore comes 4 × 2^RLD_W cycles after the start key.
- R2: Division codes 0 through 5 divide the clock by 4, 8, 16, 32, 64 and 128 in that order, so the division is 4 << code.
- R3: Division codes 6 and 7 both divide by 256.
- R4: Let edge 0 be the clock edge that samples the start key (or a refresh key). `wdt_rst_o` first rises after clock edge division × (reload + 1). This holds for every reload value from 0 to 2^RLD_W − 1.
- R5: `wdt_rst_o` stays high for exactly one cycle. The counter then reloads, and the next expiry follows one full period later.
- R6: The start key is `KEY_START` (default 16'hC3A5). It begins counting, and counting never stops before reset. A second start key while the block is running does not reload the counter.
- R7: The refresh key is `KEY_REFRESH` (default 16'h7E81). It reloads the down-counter and clears the prescaler, so the next expiry comes one full period after the edge that samples it.
- R8: A configuration write (`cfg_we_i`) is accepted only if the last key written was `KEY_UNLOCK` (default 16'h5A0F). Writing any other key value locks the configuration again. A write made while locked leaves the timeout unchanged.
- R9: A key value other than the three defined keys has no effect on counting, and the expiry time stays the same.
- R10: If a refresh key is sampled on the same edge on which the count would expire, the refresh wins. No reset pulse is produced, and the next expiry follows one full period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow watchdog clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | KEY_W (16) | Key value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_div_i | input | 3 | Division code |
| cfg_reload_i | input | RLD_W (12) | Reload value |
| wdt_rst_o | output | 1 | Reset request, one-cycle pulse on expiry |

## Verification
The expiry of the count and a refresh from software can fall in the same cycle. To provoke this, the bench starts the block under the reset configuration and waits exactly one period less one cycle. It then writes the refresh key so that the key is sampled on the edge where the final tick lands. The result is judged at the ports: `wdt_rst_o` must stay low after that edge, and the next pulse must arrive one full period later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_START,
        CMD_REFRESH,
        CMD_UNLOCK,
        CMD_OTHER
    } wdt_cmd_e;

    localparam logic [15:0] DEF_KEY_START   = 16'hC3A5;
    localparam logic [15:0] DEF_KEY_REFRESH = 16'h7E81;
    localparam logic [15:0] DEF_KEY_UNLOCK  = 16'h5A0F;

endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode #(
    parameter int          KEY_W       = 16,
    parameter logic [15:0] KEY_START   = wdt_pkg::DEF_KEY_START,
    parameter logic [15:0] KEY_REFRESH = wdt_pkg::DEF_KEY_REFRESH,
    parameter logic [15:0] KEY_UNLOCK  = wdt_pkg::DEF_KEY_UNLOCK
) (
    input  logic             key_we_i,
    input  logic [KEY_W-1:0] key_i,
    output wdt_pkg::wdt_cmd_e cmd_o
);
    always_comb begin
        cmd_o = wdt_pkg::CMD_NONE;
        if (key_we_i) begin
            if (key_i == KEY_W'(KEY_START))        cmd_o = wdt_pkg::CMD_START;
            else if (key_i == KEY_W'(KEY_REFRESH)) cmd_o = wdt_pkg::CMD_REFRESH;
            else if (key_i == KEY_W'(KEY_UNLOCK))  cmd_o = wdt_pkg::CMD_UNLOCK;
            else                                   cmd_o = wdt_pkg::CMD_OTHER;
        end
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
    parameter int CODE_W = 3,
    parameter int RLD_W  = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  wdt_pkg::wdt_cmd_e cmd_i,
    input  logic              cfg_we_i,
    input  logic [CODE_W-1:0] cfg_div_i,
    input  logic [RLD_W-1:0]  cfg_reload_i,
    output logic              running_o,
    output logic              unlocked_o,
    output logic [CODE_W-1:0] code_o,
    output logic [RLD_W-1:0]  reload_o,
    output logic              load_o
);
    typedef struct packed {
        logic              running;
        logic              unlocked;
        logic [CODE_W-1:0] code;
        logic [RLD_W-1:0]  reload;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i == wdt_pkg::CMD_START)
            st_d.running = 1'b1;
        if (cmd_i == wdt_pkg::CMD_UNLOCK)
            st_d.unlocked = 1'b1;
        else if (cmd_i != wdt_pkg::CMD_NONE)
            st_d.unlocked = 1'b0;
        if (cfg_we_i && st_q.unlocked) begin
            st_d.code   = cfg_div_i;
            st_d.reload = cfg_reload_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.running  <= 1'b0;
            st_q.unlocked <= 1'b0;
            st_q.code     <= '0;
            st_q.reload   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign running_o  = st_q.running;
    assign unlocked_o = st_q.unlocked;
    assign code_o     = st_q.code;
    assign reload_o   = st_q.reload;
    assign load_o     = ((cmd_i == wdt_pkg::CMD_START) && !st_q.running)
                      || (cmd_i == wdt_pkg::CMD_REFRESH);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int CODE_W   = 3,
    parameter int MIN_LOG2 = 2,
    parameter int STEPS    = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int PCNT_W = MIN_LOG2 + STEPS - 1;
    localparam int TOP    = STEPS - 1;

    logic [PCNT_W-1:0] pcnt_d, pcnt_q;
    logic [PCNT_W:0]   term_w;
    logic [PCNT_W-1:0] term;
    int                shift;

    always_comb begin
        shift  = MIN_LOG2 + ((int'(code_i) > TOP) ? TOP : int'(code_i));
        term_w = ((PCNT_W+1)'(1) << shift) - (PCNT_W+1)'(1);
        term   = term_w[PCNT_W-1:0];
        tick_o = run_i && !restart_i && (pcnt_q >= term);
        if (restart_i || tick_o) pcnt_d = '0;
        else if (run_i)          pcnt_d = pcnt_q + PCNT_W'(1);
        else                     pcnt_d = pcnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pcnt_q <= '0;
        else         pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int RLD_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic [RLD_W-1:0] reload_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [RLD_W-1:0] cnt;
        logic             bark;
    } dc_t;

    dc_t dc_d, dc_q;

    always_comb begin
        dc_d      = dc_q;
        dc_d.bark = 1'b0;
        if (load_i) begin
            dc_d.cnt = reload_i;
        end else if (tick_i) begin
            if (dc_q.cnt == '0) begin
                dc_d.cnt  = reload_i;
                dc_d.bark = 1'b1;
            end else begin
                dc_d.cnt = dc_q.cnt - RLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dc_q.cnt  <= '1;
            dc_q.bark <= 1'b0;
        end else begin
            dc_q <= dc_d;
        end
    end

    assign expire_o = dc_q.bark;
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int          KEY_W       = 16,
    parameter int          RLD_W       = 12,
    parameter int          CODE_W      = 3,
    parameter int          MIN_LOG2    = 2,
    parameter int          STEPS       = 7,
    parameter logic [15:0] KEY_START   = wdt_pkg::DEF_KEY_START,
    parameter logic [15:0] KEY_REFRESH = wdt_pkg::DEF_KEY_REFRESH,
    parameter logic [15:0] KEY_UNLOCK  = wdt_pkg::DEF_KEY_UNLOCK
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              key_we_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              cfg_we_i,
    input  logic [CODE_W-1:0] cfg_div_i,
    input  logic [RLD_W-1:0]  cfg_reload_i,
    output logic              wdt_rst_o
);
    wdt_pkg::wdt_cmd_e cmd;
    logic              running_q;
    logic              unlocked_q;
    logic [CODE_W-1:0] code_q;
    logic [RLD_W-1:0]  reload_q;
    logic              load;
    logic              tick;

    wdt_key_decode #(
        .KEY_W(KEY_W), .KEY_START(KEY_START),
        .KEY_REFRESH(KEY_REFRESH), .KEY_UNLOCK(KEY_UNLOCK)
    ) u_dec (
        .key_we_i(key_we_i), .key_i(key_i), .cmd_o(cmd)
    );

    wdt_ctrl #(.CODE_W(CODE_W), .RLD_W(RLD_W)) u_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd),
        .cfg_we_i(cfg_we_i), .cfg_div_i(cfg_div_i), .cfg_reload_i(cfg_reload_i),
        .running_o(running_q), .unlocked_o(unlocked_q),
        .code_o(code_q), .reload_o(reload_q), .load_o(load)
    );

    wdt_prescaler #(.CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2), .STEPS(STEPS)) u_pre (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(running_q),
        .restart_i(load), .code_i(code_q), .tick_o(tick)
    );

    wdt_downcount #(.RLD_W(RLD_W)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .tick_i(tick),
        .reload_i(reload_q), .expire_o(wdt_rst_o)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int          KEY_W       = 16,
    parameter int          RLD_W       = 12,
    parameter int          CODE_W      = 3,
    parameter logic [15:0] KEY_REFRESH = wdt_pkg::DEF_KEY_REFRESH
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              key_we_i,
    input logic [KEY_W-1:0]  key_i,
    input logic              cfg_we_i,
    input logic              wdt_rst_o,
    input logic              running_q,
    input logic              unlocked_q,
    input logic [CODE_W-1:0] code_q,
    input logic [RLD_W-1:0]  reload_q
);
    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_q |-> !wdt_rst_o);

    assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_o |=> !wdt_rst_o);

    assert_run_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_q |=> running_q);

    assert_locked_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && !unlocked_q) |=> ($stable(code_q) && $stable(reload_q)));

    assert_refresh_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_we_i && key_i == KEY_W'(KEY_REFRESH)) |=> !wdt_rst_o);
endmodule

bind wdt_top wdt_checker #(
    .KEY_W(KEY_W), .RLD_W(RLD_W), .CODE_W(CODE_W), .KEY_REFRESH(KEY_REFRESH)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_we_i(key_we_i), .key_i(key_i),
    .cfg_we_i(cfg_we_i), .wdt_rst_o(wdt_rst_o), .running_q(running_q),
    .unlocked_q(unlocked_q), .code_q(code_q), .reload_q(reload_q)
);

// File: tb/wdt_top_test.sv
module wdt_top_test;
    localparam int RW = 4;
    localparam logic [15:0] K_START  = 16'hC3A5;
    localparam logic [15:0] K_REFR   = 16'h7E81;
    localparam logic [15:0] K_UNLOCK = 16'h5A0F;
    localparam logic [15:0] K_JUNK   = 16'h1234;
    localparam int DEF_D = 4 * (1 << RW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_we = 1'b0;
    logic [15:0]   key = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_div = '0;
    logic [RW-1:0] cfg_rld = '0;
    logic          wdt_rst;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    wdt_top #(.RLD_W(RW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .key_we_i(key_we), .key_i(key),
        .cfg_we_i(cfg_we), .cfg_div_i(cfg_div), .cfg_reload_i(cfg_rld),
        .wdt_rst_o(wdt_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; key_we = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_key(input logic [15:0] v);
        key_we = 1'b1; key = v;
        @(posedge clk); @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic write_cfg(input int c, input int r);
        cfg_we = 1'b1; cfg_div = c[2:0]; cfg_rld = r[RW-1:0];
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk);
            n++;
        end while (!wdt_rst && n < 20000);
    endtask

    function automatic int divof(input int c);
        return (c >= 6) ? 256 : (4 << c);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n, d;
        do_reset();
        // R1: idle after reset
        check(wdt_rst == 1'b0, "R1 reset output", wdt_rst, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 300; i++) begin
                @(posedge clk); @(negedge clk);
                if (wdt_rst) seen++;
            end
            check(seen == 0, "R1 no pulse while idle", seen, 0);
        end
        write_key(K_START);
        measure(n);
        check(n == DEF_D, "R1 default timeout", n, DEF_D);

        // R2 R3 R4 R5: sweep division codes and reloads
        for (int c = 0; c < 8; c++) begin
            for (int ri = 0; ri < 4; ri++) begin
                int r;
                r = (ri == 0) ? 0 : (ri == 1) ? 1 : (ri == 2) ? 6 : (1 << RW) - 1;
                d = divof(c) * (r + 1);
                do_reset();
                write_key(K_UNLOCK);
                write_cfg(c, r);
                write_key(K_START);
                measure(n);
                check(n == d, (c >= 6) ? "R3 timeout div256" : "R2 R4 timeout", n, d);
                idle(1);
                check(wdt_rst == 1'b0, "R5 pulse one cycle", wdt_rst, 0);
                measure(n);
                check(n == d - 1, "R5 repeat period", n, d - 1);
            end
        end

        // R4: full reload range at /4
        for (int r = 0; r < (1 << RW); r++) begin
            do_reset();
            write_key(K_UNLOCK);
            write_cfg(0, r);
            write_key(K_START);
            measure(n);
            check(n == 4 * (r + 1), "R4 reload sweep", n, 4 * (r + 1));
        end

        // R6: second start does not reload
        do_reset();
        write_key(K_START);
        idle(20);
        write_key(K_START);
        measure(n);
        check(n == DEF_D - 21, "R6 restart ignored", n, DEF_D - 21);

        // R7: refresh mid-count
        do_reset();
        write_key(K_START);
        idle(30);
        write_key(K_REFR);
        measure(n);
        check(n == DEF_D, "R7 refresh reloads", n, DEF_D);

        // R8: locked write ignored
        do_reset();
        write_cfg(1, 2);
        write_key(K_START);
        measure(n);
        check(n == DEF_D, "R8 locked write", n, DEF_D);
        // R8: relocked by other key
        do_reset();
        write_key(K_UNLOCK);
        write_key(K_JUNK);
        write_cfg(1, 2);
        write_key(K_START);
        measure(n);
        check(n == DEF_D, "R8 relock", n, DEF_D);
        // R8: unlocked write accepted
        do_reset();
        write_key(K_UNLOCK);
        write_cfg(1, 2);
        write_key(K_START);
        measure(n);
        check(n == 24, "R8 unlocked write", n, 24);

        // R9: junk key during count
        do_reset();
        write_key(K_START);
        idle(10);
        write_key(K_JUNK);
        measure(n);
        check(n == DEF_D - 11, "R9 junk key no effect", n, DEF_D - 11);

        // R10: refresh on the expiry edge
        do_reset();
        write_key(K_START);
        idle(DEF_D - 1);
        write_key(K_REFR);
        check(wdt_rst == 1'b0, "R10 refresh beats expiry", wdt_rst, 0);
        measure(n);
        check(n == DEF_D, "R10 period after refresh", n, DEF_D);

        finish_run();
    end
endmodule